// File: doc/BRIEF.md
# Flash Command Interface Controller

This block is the command front end and write sequencer of a byte-wide NOR flash. Bus write cycles are decoded into commands, and the address and data of each command cycle are captured. The block runs block erase, byte write and lock-bit setting against a small on-chip byte array. Each of these three operations is armed only by a setup cycle that is directly followed by a confirm or data cycle. Progress and results are reported through an 8-bit status byte. Reads return array data, the status byte or identifier codes, depending on the read mode the last command selected.

The array is split into `2**BLK_W` blocks of `2**OFS_W` bytes. The block index is the upper `BLK_W` address bits. With `BLK_W=4` and `OFS_W=16` this is sixteen 64 KB blocks on a 20-bit byte address. A running erase can be paused to read, or write bytes in, other blocks. A running byte write can be paused to read elsewhere. Every modification is refused for a locked block, or when the programming supply is reported invalid. Holding the power-down pin low aborts all activity. Operation latency is a parameterized cycle count rather than cell timing.

Top module: `fcc_top`

## Requirements
- R1: After reset, and in the first cycle after `pdn_n` returns high, the read mode is array data. Reading status in that state gives 0x80.
- R2: Erase and lock-bit setting start only when the setup cycle (0x20 erase, 0x60 lock) is directly followed by its confirm byte (0xD0 erase, 0x01 lock). Any other second byte changes no array byte or lock bit and sets status bits 5 and 4 (status 0xB0).
- R3: Status byte layout: bit7 ready, bit6 erase suspended, bit5 erase error, bit4 write/lock error, bit3 supply low, bit2 write suspended, bit1 block locked, bit0 zero. 0x70 selects status reads. 0x50 clears bits 5, 4, 3 and 1.
- R4: 0x20 then 0xD0 at any address of a block sets every byte of that block to 0xFF and leaves other blocks unchanged. Ready (bit7) reads 0 while the erase runs. It finishes after `ERASE_LAT` cycles plus one cycle per byte.
- R5: 0x40 or 0x10, then a data cycle, makes the addressed byte equal to its old value AND the data, after `WRITE_LAT` cycles. Neighbouring bytes are unchanged.
- R6: 0x90 selects identifier reads: offset 0 of any block returns `MFR_ID`, offset 1 returns `DEV_ID`, offset 2 returns that block's lock bit in bit 0.
- R7: 0x60 then 0x01 sets the addressed block's lock bit. Erase or write to a locked block changes nothing and sets bit1 plus bit5 (erase, 0xA2) or bit4 (write, 0x92).
- R8: With `vpp_ok` low, an erase or write confirm changes nothing and sets bit3 plus bit5 (0xA8) or bit4 (0x98).
- R9: 0xB0 during an erase sets bit6 and bit7 and halts the erase. Array reads are then allowed. 0xD0 resumes the erase, which completes the whole block.
- R10: While an erase is suspended, a byte write to another block completes normally. A write to the block being erased is refused with bit4 set (status 0xD0).
- R11: 0xB0 during a byte write sets bit2 and bit7, and the byte stays unwritten until 0xD0 resumes the write.
- R12: While `pdn_n` is low, bus writes are ignored and any running operation is aborted with no further array change. Array contents and lock bits are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pdn_n | input | 1 | Active-low power-down / reset pin, write inhibit |
| vpp_ok | input | 1 | Programming supply valid |
| bus_we | input | 1 | One-cycle bus write strobe |
| bus_addr | input | BLK_W+OFS_W | Byte address for reads and command cycles |
| bus_wdata | input | 8 | Command or data byte |
| bus_rdata | output | 8 | Read data, registered one cycle after the address |

## Verification
The bench builds the block with `BLK_W=4`, `OFS_W=4`, `ERASE_LAT=6` and `WRITE_LAT=5`. Sixteen 16-byte blocks keep a full erase at about two dozen cycles, so block boundaries, whole-block erasure and the untouched neighbour blocks are all checked byte-exactly. The latencies are long enough for a suspend command, issued two cycles after a confirm, to land reliably inside the start delay. That makes the suspended erase and suspended write states predictable, and lets nested writes, refused writes to the erasing block, and power-down aborts be observed mid-operation.

// File: rtl/fcc_pkg.sv
// Package: command codes, status bit positions and mode/arming types
// shared by the flash command controller and its checker.
package fcc_pkg;

    localparam logic [7:0] CMD_READ_ARRAY   = 8'hFF;
    localparam logic [7:0] CMD_READ_STATUS  = 8'h70;
    localparam logic [7:0] CMD_CLEAR_STATUS = 8'h50;
    localparam logic [7:0] CMD_READ_ID      = 8'h90;
    localparam logic [7:0] CMD_ERASE_SETUP  = 8'h20;
    localparam logic [7:0] CMD_WRITE_SETUP  = 8'h40;
    localparam logic [7:0] CMD_WRITE_ALT    = 8'h10;
    localparam logic [7:0] CMD_SUSPEND      = 8'hB0;
    localparam logic [7:0] CMD_CONFIRM      = 8'hD0;
    localparam logic [7:0] CMD_LOCK_SETUP   = 8'h60;
    localparam logic [7:0] CMD_LOCK_CONFIRM = 8'h01;

    // Status byte bit positions
    localparam int SR_READY = 7;
    localparam int SR_ESUSP = 6;
    localparam int SR_EERR  = 5;
    localparam int SR_WERR  = 4;
    localparam int SR_VLOW  = 3;
    localparam int SR_WSUSP = 2;
    localparam int SR_PROT  = 1;

    typedef enum logic [1:0] {
        MODE_ARRAY,
        MODE_STATUS,
        MODE_ID
    } rd_mode_e;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_ERASE,
        PEND_WRITE,
        PEND_LOCK
    } pend_e;

endpackage

// File: rtl/fcc_countdown.sv
// Module: fcc_countdown
// Loadable down-counter that marks an operation's start latency.
// Assumes: load and clr are never both meaningful in one cycle (clr wins);
// counting pauses while en is low, so a suspend freezes the remaining time.
module fcc_countdown #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             en,
    output logic             busy,
    output logic             done
);

    logic [CNT_W-1:0] cnt;

    // Count state: load, pause, or step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= load_val;
        end else if (busy && en) begin
            if (cnt == '0) begin
                busy <= 1'b0;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end
    end

    // Completion strobe in the cycle the count expires.
    assign done = busy && en && (cnt == '0) && !clr;

endmodule

// File: rtl/fcc_lock_bank.sv
// Module: fcc_lock_bank
// One protection bit per block; a bit can only be set here.
// Assumes: reset models an unprogrammed part (all bits clear); power-down
// does not touch this state.
module fcc_lock_bank #(
    parameter int BLK_W = 4,
    localparam int NBLK = 1 << BLK_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_en,
    input  logic [BLK_W-1:0] set_blk,
    output logic [NBLK-1:0]  locks
);

    // Lock bit storage: set the addressed block's bit on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            locks <= '0;
        end else if (set_en) begin
            locks[set_blk] <= 1'b1;
        end
    end

endmodule

// File: rtl/fcc_array.sv
// Module: fcc_array
// Byte array with one write port and two combinational read ports
// (bus read and read-modify-write source).
// Assumes: reset fills the array with 0xFF (erased state); depth is kept
// small by the ADDR_W parameter for simulation.
module fcc_array #(
    parameter int ADDR_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr_a,
    output logic [7:0]        rdata_a,
    input  logic [ADDR_W-1:0] raddr_b,
    output logic [7:0]        rdata_b
);

    logic [7:0] mem [DEPTH];

    // Storage update: erased fill on reset, single byte write otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= 8'hFF;
            end
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/fcc_top.sv
// Module: fcc_top
// Command decoder, read-mode selector, status byte and the erase and
// write sequencers of a byte-wide NOR flash.
// Assumes: bus_we is a one-cycle strobe per command cycle; address and data
// are captured on that cycle; a write may only clear bits; an erase runs one
// byte per cycle after ERASE_LAT cycles; pdn_n low acts as a reset of the
// control state but keeps the array and the lock bits.
module fcc_top
    import fcc_pkg::*;
#(
    parameter int          BLK_W     = 4,
    parameter int          OFS_W     = 4,
    parameter int          ERASE_LAT = 8,
    parameter int          WRITE_LAT = 4,
    parameter logic [7:0]  MFR_ID    = 8'hA5,
    parameter logic [7:0]  DEV_ID    = 8'h3C
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   pdn_n,
    input  logic                   vpp_ok,
    input  logic                   bus_we,
    input  logic [BLK_W+OFS_W-1:0] bus_addr,
    input  logic [7:0]             bus_wdata,
    output logic [7:0]             bus_rdata
);

    localparam int ADDR_W  = BLK_W + OFS_W;
    localparam int NBLK    = 1 << BLK_W;
    localparam int MAX_LAT = (ERASE_LAT > WRITE_LAT) ? ERASE_LAT : WRITE_LAT;
    localparam int LAT_W   = $clog2(MAX_LAT + 2);

    rd_mode_e           mode;
    pend_e              pend;
    logic               esusp, wsusp;
    logic               sr_eerr, sr_werr, sr_vlow, sr_prot;
    logic               e_run;
    logic [BLK_W-1:0]   e_blk;
    logic [OFS_W-1:0]   e_ofs;
    logic [ADDR_W-1:0]  w_addr;
    logic [7:0]         w_data;
    logic               w_is_lock;
    logic               etmr_busy, etmr_done, wtmr_busy, wtmr_done;
    logic               e_active, w_active, ready;
    logic               e_start, w_start, e_wr, w_wr, lock_set;
    logic [NBLK-1:0]    locks;
    logic [BLK_W-1:0]   bus_blk;
    logic               bus_blk_locked;
    logic               arr_we;
    logic [ADDR_W-1:0]  arr_waddr;
    logic [7:0]         arr_wdata, arr_rd, rmw_old;
    logic [7:0]         status;
    logic               ctl_rst;

    assign ctl_rst        = !rst_n || !pdn_n;
    assign bus_blk        = bus_addr[ADDR_W-1:OFS_W];
    assign bus_blk_locked = locks[bus_blk];
    assign e_active       = etmr_busy || e_run;
    assign w_active       = wtmr_busy;
    assign ready          = !((e_active && !esusp) || (w_active && !wsusp));
    assign status         = {ready, esusp, sr_eerr, sr_werr, sr_vlow, wsusp, sr_prot, 1'b0};

    // Operation launch: second cycle of an armed sequence that passes all gates.
    always_comb begin
        e_start = 1'b0;
        w_start = 1'b0;
        if (bus_we && pdn_n && vpp_ok) begin
            case (pend)
                PEND_ERASE: e_start = (bus_wdata == CMD_CONFIRM) && !bus_blk_locked;
                PEND_WRITE: w_start = !bus_blk_locked && !(esusp && bus_blk == e_blk);
                PEND_LOCK:  w_start = (bus_wdata == CMD_LOCK_CONFIRM);
                default:    ;
            endcase
        end
    end

    // Command decode: read mode, arming, suspend flags and sticky errors.
    always_ff @(posedge clk) begin
        if (ctl_rst) begin
            mode    <= MODE_ARRAY;
            pend    <= PEND_NONE;
            esusp   <= 1'b0;
            wsusp   <= 1'b0;
            sr_eerr <= 1'b0;
            sr_werr <= 1'b0;
            sr_vlow <= 1'b0;
            sr_prot <= 1'b0;
        end else if (bus_we) begin
            if (pend != PEND_NONE) begin
                pend <= PEND_NONE;
                mode <= MODE_STATUS;
                case (pend)
                    PEND_ERASE: begin
                        if (bus_wdata != CMD_CONFIRM) begin
                            sr_eerr <= 1'b1;
                            sr_werr <= 1'b1;
                        end else if (!vpp_ok) begin
                            sr_vlow <= 1'b1;
                            sr_eerr <= 1'b1;
                        end else if (bus_blk_locked) begin
                            sr_prot <= 1'b1;
                            sr_eerr <= 1'b1;
                        end
                    end
                    PEND_WRITE: begin
                        if (!vpp_ok) begin
                            sr_vlow <= 1'b1;
                            sr_werr <= 1'b1;
                        end else if (bus_blk_locked) begin
                            sr_prot <= 1'b1;
                            sr_werr <= 1'b1;
                        end else if (esusp && bus_blk == e_blk) begin
                            sr_werr <= 1'b1;
                        end
                    end
                    PEND_LOCK: begin
                        if (bus_wdata != CMD_LOCK_CONFIRM) begin
                            sr_eerr <= 1'b1;
                            sr_werr <= 1'b1;
                        end else if (!vpp_ok) begin
                            sr_vlow <= 1'b1;
                            sr_werr <= 1'b1;
                        end
                    end
                    default: ;
                endcase
            end else begin
                case (bus_wdata)
                    CMD_READ_ARRAY:  mode <= MODE_ARRAY;
                    CMD_READ_STATUS: mode <= MODE_STATUS;
                    CMD_READ_ID:     mode <= MODE_ID;
                    CMD_CLEAR_STATUS: begin
                        sr_eerr <= 1'b0;
                        sr_werr <= 1'b0;
                        sr_vlow <= 1'b0;
                        sr_prot <= 1'b0;
                    end
                    CMD_ERASE_SETUP: begin
                        mode <= MODE_STATUS;
                        if (!e_active && !w_active) pend <= PEND_ERASE;
                    end
                    CMD_WRITE_SETUP, CMD_WRITE_ALT: begin
                        mode <= MODE_STATUS;
                        if (!w_active && (!e_active || esusp)) pend <= PEND_WRITE;
                    end
                    CMD_LOCK_SETUP: begin
                        mode <= MODE_STATUS;
                        if (!e_active && !w_active) pend <= PEND_LOCK;
                    end
                    CMD_SUSPEND: begin
                        mode <= MODE_STATUS;
                        if (w_active && !wsusp) begin
                            wsusp <= 1'b1;
                        end else if (e_active && !w_active && !esusp) begin
                            esusp <= 1'b1;
                        end
                    end
                    CMD_CONFIRM: begin
                        mode <= MODE_STATUS;
                        if (wsusp) begin
                            wsusp <= 1'b0;
                        end else if (esusp && !w_active) begin
                            esusp <= 1'b0;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    fcc_countdown #(.CNT_W(LAT_W)) u_etmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!pdn_n),
        .load     (e_start),
        .load_val (LAT_W'(ERASE_LAT)),
        .en       (!esusp),
        .busy     (etmr_busy),
        .done     (etmr_done)
    );

    fcc_countdown #(.CNT_W(LAT_W)) u_wtmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (!pdn_n),
        .load     (w_start),
        .load_val (LAT_W'(WRITE_LAT)),
        .en       (!wsusp),
        .busy     (wtmr_busy),
        .done     (wtmr_done)
    );

    // Erase sweep: capture the block, then clear one byte per unsuspended cycle.
    always_ff @(posedge clk) begin
        if (ctl_rst) begin
            e_run <= 1'b0;
            e_blk <= '0;
            e_ofs <= '0;
        end else begin
            if (e_start) begin
                e_blk <= bus_blk;
                e_ofs <= '0;
            end
            if (etmr_done) begin
                e_run <= 1'b1;
            end
            if (e_run && !esusp) begin
                e_ofs <= e_ofs + 1'b1;
                if (e_ofs == '1) e_run <= 1'b0;
            end
        end
    end

    // Write capture: address, data and kind of the armed write or lock op.
    always_ff @(posedge clk) begin
        if (ctl_rst) begin
            w_addr    <= '0;
            w_data    <= '0;
            w_is_lock <= 1'b0;
        end else if (w_start) begin
            w_addr    <= bus_addr;
            w_data    <= bus_wdata;
            w_is_lock <= (pend == PEND_LOCK);
        end
    end

    assign e_wr      = e_run && !esusp;
    assign w_wr      = wtmr_done && !w_is_lock;
    assign lock_set  = wtmr_done && w_is_lock;
    assign arr_we    = e_wr || w_wr;
    assign arr_waddr = e_wr ? {e_blk, e_ofs} : w_addr;
    assign arr_wdata = e_wr ? 8'hFF : (rmw_old & w_data);

    fcc_lock_bank #(.BLK_W(BLK_W)) u_locks (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (lock_set),
        .set_blk (w_addr[ADDR_W-1:OFS_W]),
        .locks   (locks)
    );

    fcc_array #(.ADDR_W(ADDR_W)) u_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (arr_we),
        .waddr   (arr_waddr),
        .wdata   (arr_wdata),
        .raddr_a (bus_addr),
        .rdata_a (arr_rd),
        .raddr_b (w_addr),
        .rdata_b (rmw_old)
    );

    // Read path: register the byte selected by the current read mode.
    always_ff @(posedge clk) begin
        if (ctl_rst) begin
            bus_rdata <= '0;
        end else begin
            case (mode)
                MODE_STATUS: bus_rdata <= status;
                MODE_ID: begin
                    if (bus_addr[OFS_W-1:0] == OFS_W'(0))      bus_rdata <= MFR_ID;
                    else if (bus_addr[OFS_W-1:0] == OFS_W'(1)) bus_rdata <= DEV_ID;
                    else if (bus_addr[OFS_W-1:0] == OFS_W'(2)) bus_rdata <= {7'b0, bus_blk_locked};
                    else                                        bus_rdata <= 8'h00;
                end
                default: bus_rdata <= arr_rd;
            endcase
        end
    end

endmodule

// File: rtl/fcc_top_chk.sv
// Module: fcc_top_chk
// Property checker for fcc_top, attached by the bind below.
// Assumes: sampled on the rising clock, disabled while rst_n is low.
module fcc_top_chk
    import fcc_pkg::*;
#(
    parameter int BLK_W = 4,
    parameter int OFS_W = 4,
    localparam int ADDR_W = BLK_W + OFS_W,
    localparam int NBLK = 1 << BLK_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pdn_n,
    input logic              vpp_ok,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input rd_mode_e          mode,
    input pend_e             pend,
    input logic              esusp,
    input logic              wsusp,
    input logic              e_active,
    input logic              w_active,
    input logic [OFS_W-1:0]  e_ofs,
    input logic [7:0]        status,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_waddr,
    input logic [NBLK-1:0]   locks
);

    assert_exit_array_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!pdn_n) |-> (mode == MODE_ARRAY && pend == PEND_NONE));

    assert_erase_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(e_active) |-> $past(pend == PEND_ERASE));

    assert_write_armed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(w_active) |-> $past(pend == PEND_WRITE || pend == PEND_LOCK));

    assert_clear_status_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && pdn_n && pend == PEND_NONE && bus_wdata == CMD_CLEAR_STATUS)
        |=> (status[SR_EERR] == 1'b0 && status[SR_WERR] == 1'b0 &&
             status[SR_VLOW] == 1'b0 && status[SR_PROT] == 1'b0));

    assert_locked_untouched_R7: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> !locks[arr_waddr[ADDR_W-1:OFS_W]]);

    assert_supply_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(e_active) || $rose(w_active)) |-> $past(vpp_ok));

    assert_suspend_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (esusp && pdn_n) |=> $stable(e_ofs));

    assert_one_engine_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({e_active && !esusp, w_active && !wsusp}));

    assert_wsusp_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wsusp |-> w_active);

    assert_powerdown_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> $past(pdn_n));

endmodule

bind fcc_top fcc_top_chk #(.BLK_W(BLK_W), .OFS_W(OFS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pdn_n     (pdn_n),
    .vpp_ok    (vpp_ok),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .mode      (mode),
    .pend      (pend),
    .esusp     (esusp),
    .wsusp     (wsusp),
    .e_active  (e_active),
    .w_active  (w_active),
    .e_ofs     (e_ofs),
    .status    (status),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr),
    .locks     (locks)
);

// File: tb/fcc_top_tb.sv
// Bench: scoreboard of expected read bytes; the driver queues expectations,
// the monitor compares them with bus_rdata one cycle after each read.
module fcc_top_tb;

    localparam int BLK_W = 4;
    localparam int OFS_W = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pdn_n = 1'b1;
    logic       vpp_ok = 1'b1;
    logic       bus_we = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;

    int         n_checks = 0;
    int         n_err = 0;
    logic       rd_valid = 1'b0;
    logic       rd_seen = 1'b0;
    logic [7:0] exp_q [$];
    string      tag_q [$];
    logic [7:0] mon_exp;
    string      mon_tag;

    always #5 clk = ~clk;

    fcc_top #(
        .BLK_W(BLK_W), .OFS_W(OFS_W), .ERASE_LAT(6), .WRITE_LAT(5),
        .MFR_ID(8'hA5), .DEV_ID(8'h3C)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .vpp_ok(vpp_ok),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    // Monitor: note which cycles carried a read, compare after the edge.
    always @(posedge clk) rd_seen <= rd_valid;

    always @(negedge clk) begin
        if (rd_seen) begin
            mon_exp = exp_q.pop_front();
            mon_tag = tag_q.pop_front();
            n_checks++;
            if (bus_rdata !== mon_exp) begin
                n_err++;
                $display("FAIL %s: got %02h expected %02h", mon_tag, bus_rdata, mon_exp);
            end
        end
    end

    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic expect_rd(input logic [7:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        bus_addr = a;
        rd_valid = 1'b1;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_valid = 1'b0;
    endtask

    // Poll status (status mode assumed) until ready or give up.
    task automatic wait_ready(input string tag);
        logic ok;
        ok = 1'b0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            bus_addr = 8'h00;
            @(negedge clk);
            if (bus_rdata[7]) begin
                ok = 1'b1;
                break;
            end
        end
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: ready never seen, got %02h expected 1xxxxxxx", tag, bus_rdata);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_rd(8'h00, 8'hFF, "R1 array mode after reset");
        bus_wr(8'h00, 8'h70);
        expect_rd(8'h00, 8'h80, "R1 idle status after reset");

        // R5: bit-clearing byte writes
        bus_wr(8'h12, 8'h40); bus_wr(8'h12, 8'h5A); wait_ready("R5 first write");
        bus_wr(8'h25, 8'h10); bus_wr(8'h25, 8'h33); wait_ready("R5 write block 2");
        bus_wr(8'h00, 8'hFF);
        expect_rd(8'h12, 8'h5A, "R5 first write value");
        bus_wr(8'h12, 8'h10); bus_wr(8'h12, 8'h0F); wait_ready("R5 second write");
        bus_wr(8'h00, 8'hFF);
        expect_rd(8'h12, 8'h0A, "R5 new equals old AND data");
        expect_rd(8'h13, 8'hFF, "R5 neighbour untouched");

        // R6: identifier readout
        bus_wr(8'h00, 8'h90);
        expect_rd(8'h00, 8'hA5, "R6 manufacturer code");
        expect_rd(8'h51, 8'h3C, "R6 device code");
        expect_rd(8'h32, 8'h00, "R6 lock bit clear");

        // R2/R3: bad confirm cycles
        bus_wr(8'h10, 8'h20); bus_wr(8'h10, 8'hFF);
        expect_rd(8'h00, 8'hB0, "R2 bad erase confirm status");
        bus_wr(8'h00, 8'hFF);
        expect_rd(8'h12, 8'h0A, "R2 bad erase confirm no change");
        bus_wr(8'h00, 8'h50); bus_wr(8'h00, 8'h70);
        expect_rd(8'h00, 8'h80, "R3 clear status");
        bus_wr(8'h30, 8'h60); bus_wr(8'h30, 8'h02);
        expect_rd(8'h00, 8'hB0, "R2 bad lock confirm status");
        bus_wr(8'h00, 8'h90);
        expect_rd(8'h32, 8'h00, "R2 bad lock confirm no lock");
        bus_wr(8'h00, 8'h50);

        // R4: block erase with block bounds
        bus_wr(8'h17, 8'h20); bus_wr(8'h17, 8'hD0);
        expect_rd(8'h00, 8'h00, "R4 busy during erase");
        wait_ready("R4 erase completes");
        expect_rd(8'h00, 8'h80, "R4 clean status after erase");
        bus_wr(8'h00, 8'hFF);
        expect_rd(8'h12, 8'hFF, "R4 erased byte");
        expect_rd(8'h1F, 8'hFF, "R4 last byte of block");
        expect_rd(8'h25, 8'h33, "R4 next block untouched");

        // R7: block lock
        bus_wr(8'h30, 8'h60); bus_wr(8'h30, 8'h01); wait_ready("R7 lock set");
        bus_wr(8'h00, 8'h90);
        expect_rd(8'h32, 8'h01, "R7 lock bit reads set");
        expect_rd(8'h22, 8'h00, "R7 other block unlocked");
        bus_wr(8'h35, 8'h40); bus_wr(8'h35, 8'h00);
        expect_rd(8'h00, 8'h92, "R7 write to locked block");
        bus_wr(8'h00, 8'h50);
        bus_wr(8'h30, 8'h20); bus_wr(8'h30, 8'hD0);
        expect_rd(8'h00, 8'hA2, "R7 erase of locked block");
        bus_wr(8'h00, 8'h50); bus_wr(8'h00, 8'hFF);
        expect_rd(8'h35, 8'hFF, "R7 locked byte unchanged");

        // R8: supply invalid
        vpp_ok = 1'b0;
        bus_wr(8'h40, 8'h40); bus_wr(8'h40, 8'h00);
        expect_rd(8'h00, 8'h98, "R8 write with supply low");
        bus_wr(8'h00, 8'h50);
        bus_wr(8'h25, 8'h20); bus_wr(8'h25, 8'hD0);
        expect_rd(8'h00, 8'hA8, "R8 erase with supply low");
        bus_wr(8'h00, 8'h50);
        vpp_ok = 1'b1;
        bus_wr(8'h00, 8'hFF);
        expect_rd(8'h40, 8'hFF, "R8 byte unchanged");
        expect_rd(8'h25, 8'h33, "R8 block unchanged");

        // R9/R10: erase suspend and nested write
        bus_wr(8'h50, 8'h40); bus_wr(8'h50, 8'h11); wait_ready("R9 preload");
        bus_wr(8'h50, 8'h20); bus_wr(8'h50, 8'hD0);
        bus_wr(8'h00, 8'hB0);
        expect_rd(8'h00, 8'hC0, "R9 erase suspended status");
        bus_wr(8'h00, 8'hFF);
        expect_rd(8'h50, 8'h11, "R9 erase halted");
        expect_rd(8'h25, 8'h33, "R9 read other block");
        bus_wr(8'h26, 8'h40); bus_wr(8'h26, 8'h44); wait_ready("R10 nested write");
        bus_wr(8'h00, 8'hFF);
        expect_rd(8'h26, 8'h44, "R10 nested write value");
        bus_wr(8'h51, 8'h40); bus_wr(8'h51, 8'h00);
        expect_rd(8'h00, 8'hD0, "R10 write to erasing block refused");
        bus_wr(8'h00, 8'h50);
        expect_rd(8'h00, 8'hC0, "R10 status after clear");
        bus_wr(8'h00, 8'hD0); wait_ready("R9 resumed erase");
        bus_wr(8'h00, 8'hFF);
        expect_rd(8'h50, 8'hFF, "R9 erase finished after resume");
        expect_rd(8'h5F, 8'hFF, "R9 whole block erased");

        // R11: write suspend
        bus_wr(8'h60, 8'h40); bus_wr(8'h60, 8'h0C);
        bus_wr(8'h00, 8'hB0);
        expect_rd(8'h00, 8'h84, "R11 write suspended status");
        bus_wr(8'h00, 8'hFF);
        expect_rd(8'h60, 8'hFF, "R11 byte still unwritten");
        expect_rd(8'h26, 8'h44, "R11 read elsewhere");
        bus_wr(8'h00, 8'hD0); wait_ready("R11 resumed write");
        bus_wr(8'h00, 8'hFF);
        expect_rd(8'h60, 8'h0C, "R11 write done after resume");

        // R12/R1: power-down abort
        bus_wr(8'h60, 8'h20); bus_wr(8'h60, 8'hD0);
        @(negedge clk);
        pdn_n = 1'b0;
        bus_wr(8'h70, 8'h20); bus_wr(8'h70, 8'hD0);
        @(negedge clk);
        pdn_n = 1'b1;
        expect_rd(8'h60, 8'h0C, "R12 erase aborted, R1 array mode");
        bus_wr(8'h00, 8'h70);
        expect_rd(8'h00, 8'h80, "R12 writes ignored, idle status");
        bus_wr(8'h00, 8'h90);
        expect_rd(8'h32, 8'h01, "R12 lock bit kept");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_err++;
            $display("FAIL scoreboard: got %0d pending expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    end

endmodule